// File: doc/BRIEF.md
# Registered Tri-Port Bus Exchanger

This block moves words between one processor-side port (A) and two memory-side ports (1B and 2B). A typical use is interleaving a processor bus across an even bank and an odd bank. Each direction of each B port has its own storage register: A-to-1B, A-to-2B, 1B-to-A and 2B-to-A. Each register has its own active-low load enable, and all four share one rising-edge clock. One A word can be written to both B ports in a single cycle.

The A-port source select and the two active-low output enables are captured in a control register on the clock edge. Turning a port around or switching the A source therefore only happens at an edge. Each bidirectional pin group is modelled as a data-in bus, a data-out bus, an output-enable flag, and an input that says whether something outside drives the wire. A keeper register per port stands in for bus-hold. When neither side drives a port, the value the block samples is the last value driven onto it. Nothing prevents A and the B ports from driving out in the same cycle.

Top module: `tri_port_exchanger`

## Requirements
- R1: A synchronous active-high reset clears all four data registers, the captured select and every port keeper, and leaves `a_oe`, `b1_oe` and `b2_oe` low one edge later.
- R2: On a rising edge with `ce_a1b_n` low, the A-to-1B register loads the A-port value, which appears on `b1_out` after that edge. With `ce_a2b_n` low, the A-to-2B register loads it, shown on `b2_out`.
- R3: While a register's load enable is high at an edge, its value and the output it feeds do not change.
- R4: With `ce_a1b_n` and `ce_a2b_n` both low at one edge, the same A word appears on `b1_out` and `b2_out`.
- R5: `sel_b1` is captured at the edge. A captured 1 routes the 1B-to-A register to `a_out`, and a captured 0 routes the 2B-to-A register.
- R6: When the select changes and the newly selected B-to-A register loads at the same edge, `a_out` shows the newly loaded word right after that edge.
- R7: `oe_a_n` is captured at the edge: a captured 0 raises `a_oe`, and a captured 1 lowers it (A floats).
- R8: `oe_b_n` is captured at the edge and drives `b1_oe` and `b2_oe` together (0 enables both, 1 floats both).
- R9: When a port is driven neither from outside (`*_drv` low) nor by the block (`*_oe` low), the value the block samples from it is the last value driven onto it, whether that last drive came from outside or from the block itself.
- R10: `a_oe` and `b1_oe`/`b2_oe` can all be high in the same cycle. No interlock blocks it.
- R11: When a port is driven both from outside and by the block, the registers sample the outside value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Value on the A wires from the outside driver |
| a_drv | input | 1 | An outside driver is active on A |
| a_out | output | W | Word the block drives onto A |
| a_oe | output | 1 | Block drives A |
| b1_in | input | W | Value on the 1B wires from the outside driver |
| b1_drv | input | 1 | An outside driver is active on 1B |
| b1_out | output | W | Word the block drives onto 1B |
| b1_oe | output | 1 | Block drives 1B |
| b2_in | input | W | Value on the 2B wires from the outside driver |
| b2_drv | input | 1 | An outside driver is active on 2B |
| b2_out | output | W | Word the block drives onto 2B |
| b2_oe | output | 1 | Block drives 2B |
| ce_a1b_n | input | 1 | Load enable, A-to-1B register, active low |
| ce_a2b_n | input | 1 | Load enable, A-to-2B register, active low |
| ce_b1a_n | input | 1 | Load enable, 1B-to-A register, active low |
| ce_b2a_n | input | 1 | Load enable, 2B-to-A register, active low |
| sel_b1 | input | 1 | A source select: 1 = 1B-to-A register, 0 = 2B-to-A register |
| oe_a_n | input | 1 | A output enable, active low, captured at the edge |
| oe_b_n | input | 1 | Shared output enable for both B ports, active low, captured at the edge |

## Verification
The assertions check on every cycle the behaviour that the inputs and outputs show directly:
- each externally driven load lands on the right output one edge later;
- outputs whose register is not enabled stay unchanged;
- a newly selected B-to-A word reaches `a_out` after the edge;
- both captured enables follow their inputs, and reset empties the block.

Bus-hold can only be shown by the bench's scenarios, because the held value is seen only through a later load: an undriven A port after an outside drive, and an undriven 1B port after the block's own drive. The same holds for a keeper being cleared by reset, for priority between an outside driver and the block's own drive, and for A and B being enabled together.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

   // Port indices of the three pin groups
   localparam int PORT_A  = 0;
   localparam int PORT_B1 = 1;
   localparam int PORT_B2 = 2;
   localparam int NPORT   = 3;

   // Data path indices
   typedef enum logic [1:0] {
      PATH_A1B = 2'd0,
      PATH_A2B = 2'd1,
      PATH_B1A = 2'd2,
      PATH_B2A = 2'd3
   } path_e;
   localparam int NPATH = 4;

   // Captured control word
   typedef struct packed {
      logic sel_b1;   // 1: 1B-to-A feeds A, 0: 2B-to-A feeds A
      logic a_en;     // block drives A
      logic b_en;     // block drives both B ports
   } xchg_ctrl_t;

   localparam xchg_ctrl_t CTRL_RESET = '{sel_b1: 1'b0, a_en: 1'b0, b_en: 1'b0};

   // Which port each data path samples from
   function automatic int path_src(input int p);
      case (p)
         int'(PATH_A1B): return PORT_A;
         int'(PATH_A2B): return PORT_A;
         int'(PATH_B1A): return PORT_B1;
         default:        return PORT_B2;
      endcase
   endfunction

endpackage

// File: rtl/xchg_port_keeper.sv
module xchg_port_keeper #(
   parameter int W       = 12,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ext_drv,
   input  logic [W-1:0] ext_val,
   input  logic         own_drv,
   input  logic [W-1:0] own_val,
   output logic [W-1:0] bus_val
);

   logic [W-1:0] driven_val;
   logic         any_drv;

   // Outside driver wins a contention (R11)
   always_comb begin
      any_drv    = ext_drv | own_drv;
      driven_val = ext_drv ? ext_val : own_val;
   end

   generate
      if (HOLD_EN) begin : g_hold
         logic [W-1:0] hold_q;
         always_ff @(posedge clk) begin
            if (rst)
               hold_q <= '0;
            else if (any_drv)
               hold_q <= driven_val;
         end
         assign bus_val = any_drv ? driven_val : hold_q;
      end else begin : g_nohold
         assign bus_val = any_drv ? driven_val : '0;
      end
   endgenerate

endmodule

// File: rtl/xchg_path_reg.sv
module xchg_path_reg #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (!ld_n)
         q <= d;
   end

endmodule

// File: rtl/xchg_ctrl_reg.sv
module xchg_ctrl_reg
   import xchg_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       sel_b1,
   input  logic       oe_a_n,
   input  logic       oe_b_n,
   output xchg_ctrl_t ctrl
);

   xchg_ctrl_t nxt;

   always_comb begin
      nxt.sel_b1 = sel_b1;
      nxt.a_en   = ~oe_a_n;
      nxt.b_en   = ~oe_b_n;
   end

   always_ff @(posedge clk) begin
      if (rst)
         ctrl <= CTRL_RESET;
      else
         ctrl <= nxt;
   end

endmodule

// File: rtl/tri_port_exchanger.sv
module tri_port_exchanger
   import xchg_pkg::*;
#(
   parameter int W       = 12,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_in,
   input  logic         a_drv,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b1_in,
   input  logic         b1_drv,
   output logic [W-1:0] b1_out,
   output logic         b1_oe,
   input  logic [W-1:0] b2_in,
   input  logic         b2_drv,
   output logic [W-1:0] b2_out,
   output logic         b2_oe,
   input  logic         ce_a1b_n,
   input  logic         ce_a2b_n,
   input  logic         ce_b1a_n,
   input  logic         ce_b2a_n,
   input  logic         sel_b1,
   input  logic         oe_a_n,
   input  logic         oe_b_n
);

   localparam int WMAX = 1024;

   generate
      if (W < 1 || W > WMAX) begin : g_bad_width
         $error("tri_port_exchanger: W out of range");
      end
   endgenerate

   xchg_ctrl_t ctrl;

   logic [W-1:0] ext_val [NPORT];
   logic         ext_drv [NPORT];
   logic [W-1:0] own_val [NPORT];
   logic         own_drv [NPORT];
   logic [W-1:0] bus_val [NPORT];

   logic         ld_n    [NPATH];
   logic [W-1:0] path_q  [NPATH];

   // Control register: select and both enables change only on an edge
   xchg_ctrl_reg u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .sel_b1 (sel_b1),
      .oe_a_n (oe_a_n),
      .oe_b_n (oe_b_n),
      .ctrl   (ctrl)
   );

   // Gather the pin groups into indexed arrays
   always_comb begin
      ext_val[PORT_A]  = a_in;
      ext_val[PORT_B1] = b1_in;
      ext_val[PORT_B2] = b2_in;
      ext_drv[PORT_A]  = a_drv;
      ext_drv[PORT_B1] = b1_drv;
      ext_drv[PORT_B2] = b2_drv;
      own_val[PORT_A]  = a_out;
      own_val[PORT_B1] = b1_out;
      own_val[PORT_B2] = b2_out;
      own_drv[PORT_A]  = a_oe;
      own_drv[PORT_B1] = b1_oe;
      own_drv[PORT_B2] = b2_oe;
      ld_n[PATH_A1B]   = ce_a1b_n;
      ld_n[PATH_A2B]   = ce_a2b_n;
      ld_n[PATH_B1A]   = ce_b1a_n;
      ld_n[PATH_B2A]   = ce_b2a_n;
   end

   // One keeper per pin group resolves the wire value
   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         xchg_port_keeper #(.W(W), .HOLD_EN(HOLD_EN)) u_keep (
            .clk     (clk),
            .rst     (rst),
            .ext_drv (ext_drv[p]),
            .ext_val (ext_val[p]),
            .own_drv (own_drv[p]),
            .own_val (own_val[p]),
            .bus_val (bus_val[p])
         );
      end
   endgenerate

   // Four independent storage registers
   generate
      for (genvar i = 0; i < NPATH; i++) begin : g_path
         localparam int SRC = path_src(i);
         xchg_path_reg #(.W(W)) u_reg (
            .clk  (clk),
            .rst  (rst),
            .ld_n (ld_n[i]),
            .d    (bus_val[SRC]),
            .q    (path_q[i])
         );
      end
   endgenerate

   // Output side
   always_comb begin
      a_out  = ctrl.sel_b1 ? path_q[PATH_B1A] : path_q[PATH_B2A];
      a_oe   = ctrl.a_en;
      b1_out = path_q[PATH_A1B];
      b2_out = path_q[PATH_A2B];
      b1_oe  = ctrl.b_en;
      b2_oe  = ctrl.b_en;
   end

endmodule

// File: rtl/tri_port_exchanger_chk.sv
module tri_port_exchanger_chk #(
   parameter int W = 12
) (
   input logic         clk,
   input logic         rst,
   input logic [W-1:0] a_in,
   input logic         a_drv,
   input logic [W-1:0] a_out,
   input logic         a_oe,
   input logic [W-1:0] b1_in,
   input logic         b1_drv,
   input logic [W-1:0] b1_out,
   input logic         b1_oe,
   input logic [W-1:0] b2_in,
   input logic         b2_drv,
   input logic [W-1:0] b2_out,
   input logic         b2_oe,
   input logic         ce_a1b_n,
   input logic         ce_a2b_n,
   input logic         ce_b1a_n,
   input logic         ce_b2a_n,
   input logic         sel_b1,
   input logic         oe_a_n,
   input logic         oe_b_n
);

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!a_oe && !b1_oe && !b2_oe && a_out == '0 && b1_out == '0 && b2_out == '0));

   assert_load_1b_R2: assert property (@(posedge clk) disable iff (rst)
      (!ce_a1b_n && a_drv) |=> b1_out == $past(a_in));

   assert_load_2b_R2: assert property (@(posedge clk) disable iff (rst)
      (!ce_a2b_n && a_drv) |=> b2_out == $past(a_in));

   assert_hold_1b_R3: assert property (@(posedge clk) disable iff (rst)
      ce_a1b_n |=> $stable(b1_out));

   assert_hold_2b_R3: assert property (@(posedge clk) disable iff (rst)
      ce_a2b_n |=> $stable(b2_out));

   assert_broadcast_R4: assert property (@(posedge clk) disable iff (rst)
      (!ce_a1b_n && !ce_a2b_n) |=> b1_out == b2_out);

   assert_sel_1b_R5: assert property (@(posedge clk) disable iff (rst)
      (sel_b1 && !ce_b1a_n && b1_drv) |=> a_out == $past(b1_in));

   assert_sel_2b_R6: assert property (@(posedge clk) disable iff (rst)
      (!sel_b1 && !ce_b2a_n && b2_drv) |=> a_out == $past(b2_in));

   assert_a_on_R7: assert property (@(posedge clk) disable iff (rst)
      !oe_a_n |=> a_oe);

   assert_a_off_R7: assert property (@(posedge clk) disable iff (rst)
      oe_a_n |=> !a_oe);

   assert_b_on_R8: assert property (@(posedge clk) disable iff (rst)
      !oe_b_n |=> (b1_oe && b2_oe));

   assert_b_off_R8: assert property (@(posedge clk) disable iff (rst)
      oe_b_n |=> (!b1_oe && !b2_oe));

endmodule

bind tri_port_exchanger tri_port_exchanger_chk #(.W(W)) u_chk (.*);

// File: tb/tri_port_exchanger_tb.sv
module tri_port_exchanger_tb;

   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
   logic         a_drv = 1'b0, b1_drv = 1'b0, b2_drv = 1'b0;
   logic [W-1:0] a_out, b1_out, b2_out;
   logic         a_oe, b1_oe, b2_oe;
   logic         ce_a1b_n = 1'b1, ce_a2b_n = 1'b1, ce_b1a_n = 1'b1, ce_b2a_n = 1'b1;
   logic         sel_b1 = 1'b0, oe_a_n = 1'b1, oe_b_n = 1'b1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   tri_port_exchanger #(.W(W)) u_dut (.*);

   // Stimulus and expected-result vector
   typedef struct packed {
      logic [11:0] a;
      logic [11:0] b1;
      logic [11:0] b2;
      logic [2:0]  drv;     // {a, b1, b2}
      logic [3:0]  ce;      // {a1b, a2b, b1a, b2a}, active low
      logic        sel;
      logic        oea_n;
      logic        oeb_n;
      logic [11:0] x_a;
      logic        x_aoe;
      logic [11:0] x_b1;
      logic [11:0] x_b2;
      logic        x_boe;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      // R2 load A-to-1B, R8 B enabled, R7 A off
      '{12'h123, 12'h000, 12'h000, 3'b100, 4'b0111, 1'b0, 1'b1, 1'b0,
        12'h000, 1'b0, 12'h123, 12'h000, 1'b1, 4'd2},
      // R2 load A-to-2B
      '{12'h456, 12'h000, 12'h000, 3'b100, 4'b1011, 1'b0, 1'b1, 1'b0,
        12'h000, 1'b0, 12'h123, 12'h456, 1'b1, 4'd2},
      // R4 broadcast
      '{12'hABC, 12'h000, 12'h000, 3'b100, 4'b0011, 1'b0, 1'b1, 1'b0,
        12'h000, 1'b0, 12'hABC, 12'hABC, 1'b1, 4'd4},
      // R3 all enables high
      '{12'h777, 12'h000, 12'h000, 3'b100, 4'b1111, 1'b0, 1'b1, 1'b0,
        12'h000, 1'b0, 12'hABC, 12'hABC, 1'b1, 4'd3},
      // R5 load 1B-to-A, select 1; R7 A on; R8 B off
      '{12'h000, 12'h311, 12'h622, 3'b011, 4'b1101, 1'b1, 1'b0, 1'b1,
        12'h311, 1'b1, 12'hABC, 12'hABC, 1'b0, 4'd5},
      // R5 load 2B-to-A while 1B selected: A unchanged
      '{12'h000, 12'h999, 12'h622, 3'b011, 4'b1110, 1'b1, 1'b0, 1'b1,
        12'h311, 1'b1, 12'hABC, 12'hABC, 1'b0, 4'd5},
      // R5 select 0 shows 2B-to-A
      '{12'h000, 12'h999, 12'h622, 3'b011, 4'b1111, 1'b0, 1'b0, 1'b1,
        12'h622, 1'b1, 12'hABC, 12'hABC, 1'b0, 4'd5},
      // R6 select change with same-edge load
      '{12'h000, 12'h0F0, 12'h622, 3'b011, 4'b1101, 1'b1, 1'b0, 1'b1,
        12'h0F0, 1'b1, 12'hABC, 12'hABC, 1'b0, 4'd6},
      // R10 A and B enabled together
      '{12'h000, 12'h000, 12'h000, 3'b000, 4'b1111, 1'b1, 1'b0, 1'b0,
        12'h0F0, 1'b1, 12'hABC, 12'hABC, 1'b1, 4'd10},
      // R11 outside A driver beats own A drive
      '{12'h2D2, 12'h000, 12'h000, 3'b100, 4'b0111, 1'b1, 1'b0, 1'b0,
        12'h0F0, 1'b1, 12'h2D2, 12'hABC, 1'b1, 4'd11}
   };

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b1,
                        input logic [W-1:0] b2, input logic [2:0] drv,
                        input logic [3:0] ce, input logic sel,
                        input logic oea, input logic oeb);
      a_in = a; b1_in = b1; b2_in = b2;
      {a_drv, b1_drv, b2_drv} = drv;
      {ce_a1b_n, ce_a2b_n, ce_b1a_n, ce_b2a_n} = ce;
      sel_b1 = sel; oe_a_n = oea; oe_b_n = oeb;
   endtask

   // Inputs change at the falling edge; results are read one falling edge later
   task automatic cycle();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      cycle();
      cycle();
      // R1 reset state
      chk("R1", "a_oe", W'(a_oe), W'(0));
      chk("R1", "b1_oe", W'(b1_oe), W'(0));
      chk("R1", "b2_oe", W'(b2_oe), W'(0));
      chk("R1", "a_out", a_out, '0);
      chk("R1", "b1_out", b1_out, '0);
      chk("R1", "b2_out", b2_out, '0);
      rst = 1'b0;
      drive('0, '0, '0, 3'b000, 4'b1111, 1'b0, 1'b1, 1'b1);
      cycle();

      for (int i = 0; i < NV; i++) begin
         string r;
         r = $sformatf("R%0d vec%0d", VEC[i].req, i);
         drive(VEC[i].a, VEC[i].b1, VEC[i].b2, VEC[i].drv, VEC[i].ce,
               VEC[i].sel, VEC[i].oea_n, VEC[i].oeb_n);
         cycle();
         chk(r, "a_out", a_out, VEC[i].x_a);
         chk(r, "a_oe", W'(a_oe), W'(VEC[i].x_aoe));
         chk(r, "b1_out", b1_out, VEC[i].x_b1);
         chk(r, "b2_out", b2_out, VEC[i].x_b2);
         chk(r, "b1_oe", W'(b1_oe), W'(VEC[i].x_boe));
         chk(r, "b2_oe", W'(b2_oe), W'(VEC[i].x_boe));
      end

      // R9: A undriven after an outside drive keeps that value
      drive(12'h5A5, '0, '0, 3'b100, 4'b1111, 1'b1, 1'b1, 1'b0);
      cycle();
      chk("R7", "a_oe off", W'(a_oe), W'(0));
      drive(12'hFFF, '0, '0, 3'b000, 4'b0111, 1'b1, 1'b1, 1'b0);
      cycle();
      chk("R9", "held A into b1_out", b1_out, 12'h5A5);

      // R9: 1B undriven after the block's own drive keeps that value
      drive('0, '0, '0, 3'b000, 4'b1111, 1'b1, 1'b1, 1'b1);
      cycle();
      chk("R8", "b1_oe off", W'(b1_oe), W'(0));
      drive('0, 12'hFFF, '0, 3'b000, 4'b1101, 1'b1, 1'b0, 1'b1);
      cycle();
      chk("R9", "held 1B into a_out", a_out, 12'h5A5);
      chk("R7", "a_oe on", W'(a_oe), W'(1));

      // R6: select back to 2B with a same-edge load
      drive('0, '0, 12'h3C3, 3'b001, 4'b1110, 1'b0, 1'b0, 1'b1);
      cycle();
      chk("R6", "a_out after 1->0 select", a_out, 12'h3C3);

      // R1: reset in mid run
      drive('0, '0, '0, 3'b000, 4'b1111, 1'b1, 1'b0, 1'b0);
      rst = 1'b1;
      cycle();
      chk("R1", "a_oe mid", W'(a_oe), W'(0));
      chk("R1", "b1_oe mid", W'(b1_oe), W'(0));
      chk("R1", "a_out mid", a_out, '0);
      chk("R1", "b1_out mid", b1_out, '0);
      rst = 1'b0;
      drive('0, '0, '0, 3'b000, 4'b1111, 1'b0, 1'b1, 1'b1);
      cycle();
      // R1: keeper cleared, so an undriven A loads zero
      drive(12'hFFF, '0, '0, 3'b000, 4'b0111, 1'b0, 1'b1, 1'b0);
      cycle();
      chk("R1", "keeper cleared", b1_out, '0);
      chk("R8", "b2_oe on", W'(b2_oe), W'(1));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule